// File: doc/BRIEF.md
# Configurable Macrocell Register Cell

This block is one storage cell of a product-term style logic fabric. A set of static configuration inputs turns it into a D, T, JK or SR flip-flop. A bypass setting instead passes the first data term straight through to the output. The same configuration picks how the cell is clocked. It can use a global clock source, a global clock source gated by a product-term enable, a product-term clock, or no clock at all. It can also assert an optional inversion on the output.

All sequential logic runs on one system clock, `sys_clk`. The global clock pins and the product-term clock are treated as level signals. Each is sampled once, and a rising edge of the sampled level becomes a one-cycle update enable. There are two global clock sources. Each one takes either global pin, true or inverted, and the configuration chooses which source the cell listens to.

The product-term preset and clear are asynchronous and active high. Clear wins when both are asserted. The shared active-low global clear is ORed into the clear only when the cell's enable bit for it is set. The stored bit resets to 0. A register that must start high stores the inverted function and sets the output inversion.

Top module: `prl_reg_cell`

## Requirements
- R1: While `rst_n` is low the stored bit is 0, so with `cfg_out_inv`=0 `cell_out` is 0.
- R2: With `cfg_ff_kind`=0 (D), each clock event loads `term_a` into the stored bit.
- R3: With `cfg_ff_kind`=1 (T), a clock event inverts the stored bit when `term_a`=1 and keeps it when `term_a`=0.
- R4: With `cfg_ff_kind`=2 (JK, J=`term_a`, K=`term_b`), a clock event sets the bit on 1/0, clears it on 0/1, keeps it on 0/0 and toggles it on 1/1.
- R5: With `cfg_ff_kind`=3 (SR, S=`term_a`, R=`term_b`), a clock event sets the bit on 1/0, clears it on 0/1, and keeps it on 0/0 and on 1/1.
- R6: With `cfg_bypass`=1, `cell_out` equals `term_a` XOR `cfg_out_inv` at once, with no clock edge needed.
- R7: With `cfg_clk_mode`=0, a clock event occurs once for each rising edge of the selected global source. The stored bit changes on the second `sys_clk` edge after the source rises. Holding the source high or letting it fall causes no further update.
- R8: With `cfg_clk_mode`=1, a rising edge of the global source updates the bit only while `pt_ena`=1.
- R9: With `cfg_clk_mode`=2, only rising edges of `pt_clk` update the bit, and global pin edges are ignored. With `cfg_clk_mode`=3, the bit is never updated by a clock event.
- R10: Global source s is `gclk_pin[cfg_gsrc_pin[s]]` XOR `cfg_gsrc_inv[s]`, and `cfg_gsrc_sel` picks s. With inversion, a falling edge of the pin is the event. Edges on a pin that is not routed to the selected source are ignored.
- R11: `pt_clr`=1 forces the stored bit to 0 and `pt_pre`=1 forces it to 1, both without waiting for a clock edge. Clear wins when both are high.
- R12: `gclr_n`=0 clears the stored bit asynchronously only when `cfg_gclr_en`=1, and has no effect otherwise.
- R13: With `cfg_out_inv`=1 and no bypass, `cell_out` is the inverse of the stored bit, so after reset the output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for all sampling and storage |
| rst_n | input | 1 | Active-low asynchronous power-up reset, stored bit to 0 |
| cfg_ff_kind | input | 2 | Storage type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_bypass | input | 1 | 1 routes `term_a` to the output |
| cfg_clk_mode | input | 2 | 0 global, 1 global with enable, 2 product-term clock, 3 none |
| cfg_gsrc_pin | input | NUM_GSRC*PSW | Pin index for each global source |
| cfg_gsrc_inv | input | NUM_GSRC | Inversion for each global source |
| cfg_gsrc_sel | input | SSW | Global source used by this cell |
| cfg_gclr_en | input | 1 | Lets `gclr_n` clear this cell |
| cfg_out_inv | input | 1 | Inverts the output |
| term_a | input | 1 | First data term (D, T, J or S) |
| term_b | input | 1 | Second data term (K or R) |
| pt_clk | input | 1 | Product-term clock level |
| pt_ena | input | 1 | Product-term clock enable, active high |
| pt_pre | input | 1 | Product-term asynchronous preset, active high |
| pt_clr | input | 1 | Product-term asynchronous clear, active high |
| gclk_pin | input | NUM_GPINS | Global clock pin levels |
| gclr_n | input | 1 | Shared global clear, active low |
| cell_out | output | 1 | Registered or bypassed value after optional inversion |

## Verification
A clock event is due two `sys_clk` edges after its source level changes: one edge to sample the level and one to compare it with the previous sample and load the bit. The bench raises a source at a falling clock edge and reads `cell_out` two falling edges later. In one directed case it also reads one falling edge earlier to confirm the value has not changed yet. The bypass path and the asynchronous preset and clears have no latency. Their checks are read a few nanoseconds after the input changes, inside the low half of the clock, so no rising edge can explain the result.

// File: rtl/rcell_pkg.sv
package rcell_pkg;

  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_kind_e;

  typedef enum logic [1:0] {
    CK_GLOBAL    = 2'd0,
    CK_GLOBAL_EN = 2'd1,
    CK_TERM      = 2'd2,
    CK_OFF       = 2'd3
  } clk_mode_e;

  // next stored value for a clock event
  function automatic logic ff_next(ff_kind_e kind, logic q, logic a, logic b);
    logic n;
    case (kind)
      FF_D:    n = a;
      FF_T:    n = q ^ a;
      FF_JK:   n = (a & ~q) | (~b & q);
      FF_SR:   n = (a & ~b) ? 1'b1 : ((b & ~a) ? 1'b0 : q);
      default: n = q;
    endcase
    return n;
  endfunction

  // selected clock event for a clock mode
  function automatic logic evt_pick(clk_mode_e mode, logic g_rise, logic t_rise, logic ena);
    logic f;
    case (mode)
      CK_GLOBAL:    f = g_rise;
      CK_GLOBAL_EN: f = g_rise & ena;
      CK_TERM:      f = t_rise;
      default:      f = 1'b0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/rc_gclk_mux.sv
module rc_gclk_mux #(
  parameter int NUM_GPINS = 2,
  parameter int NUM_GSRC  = 2,
  localparam int PSW = (NUM_GPINS > 1) ? $clog2(NUM_GPINS) : 1,
  localparam int SSW = (NUM_GSRC > 1) ? $clog2(NUM_GSRC) : 1
) (
  input  logic [NUM_GPINS-1:0]    pins,
  input  logic [NUM_GSRC*PSW-1:0] src_pin,
  input  logic [NUM_GSRC-1:0]     src_inv,
  input  logic [SSW-1:0]          src_sel,
  output logic                    level
);
  logic [NUM_GSRC-1:0] src_lvl;

  for (genvar s = 0; s < NUM_GSRC; s++) begin : g_src
    logic [PSW-1:0] idx;
    assign idx        = src_pin[s*PSW +: PSW];
    assign src_lvl[s] = pins[idx] ^ src_inv[s];
  end

  assign level = src_lvl[src_sel];
endmodule

// File: rtl/rc_edge_evt.sv
module rc_edge_evt
  import rcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      g_level,
  input  logic      t_level,
  input  logic      ena,
  input  clk_mode_e mode,
  output logic      g_rise,
  output logic      t_rise,
  output logic      fire
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] raw, smp, prv, rise;

  assign raw = {t_level, g_level};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp <= '0;
      prv <= '0;
    end else begin
      smp <= raw;
      prv <= smp;
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_rise_det
    assign rise[k] = smp[k] & ~prv[k];
  end

  assign g_rise = rise[0];
  assign t_rise = rise[1];
  assign fire   = evt_pick(mode, g_rise, t_rise, ena);
endmodule

// File: rtl/rc_state_reg.sv
module rc_state_reg
  import rcell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  ff_kind_e kind,
  input  logic     a,
  input  logic     b,
  input  logic     clr_any,
  input  logic     pre_any,
  output logic     q
);
  logic q_nx;

  assign q_nx = ff_next(kind, q, a, b);

  always_ff @(posedge clk or negedge rst_n or posedge clr_any or posedge pre_any) begin
    if (!rst_n)       q <= 1'b0;
    else if (clr_any) q <= 1'b0;
    else if (pre_any) q <= 1'b1;
    else if (fire)    q <= q_nx;
  end
endmodule

// File: rtl/prl_reg_cell.sv
module prl_reg_cell
  import rcell_pkg::*;
#(
  parameter int NUM_GPINS = 2,
  parameter int NUM_GSRC  = 2,
  localparam int PSW = (NUM_GPINS > 1) ? $clog2(NUM_GPINS) : 1,
  localparam int SSW = (NUM_GSRC > 1) ? $clog2(NUM_GSRC) : 1
) (
  input  logic                    sys_clk,
  input  logic                    rst_n,
  input  logic [1:0]              cfg_ff_kind,
  input  logic                    cfg_bypass,
  input  logic [1:0]              cfg_clk_mode,
  input  logic [NUM_GSRC*PSW-1:0] cfg_gsrc_pin,
  input  logic [NUM_GSRC-1:0]     cfg_gsrc_inv,
  input  logic [SSW-1:0]          cfg_gsrc_sel,
  input  logic                    cfg_gclr_en,
  input  logic                    cfg_out_inv,
  input  logic                    term_a,
  input  logic                    term_b,
  input  logic                    pt_clk,
  input  logic                    pt_ena,
  input  logic                    pt_pre,
  input  logic                    pt_clr,
  input  logic [NUM_GPINS-1:0]    gclk_pin,
  input  logic                    gclr_n,
  output logic                    cell_out
);
  ff_kind_e  kind_w;
  clk_mode_e mode_w;
  logic      glevel_w;
  logic      g_rise_w, t_rise_w, fire_w;
  logic      clr_any_w, pre_any_w;
  logic      stored_w;

  assign kind_w    = ff_kind_e'(cfg_ff_kind);
  assign mode_w    = clk_mode_e'(cfg_clk_mode);
  assign clr_any_w = pt_clr | (cfg_gclr_en & ~gclr_n);
  assign pre_any_w = pt_pre;

  rc_gclk_mux #(.NUM_GPINS(NUM_GPINS), .NUM_GSRC(NUM_GSRC)) u_gmux (
    .pins    (gclk_pin),
    .src_pin (cfg_gsrc_pin),
    .src_inv (cfg_gsrc_inv),
    .src_sel (cfg_gsrc_sel),
    .level   (glevel_w)
  );

  rc_edge_evt u_evt (
    .clk     (sys_clk),
    .rst_n   (rst_n),
    .g_level (glevel_w),
    .t_level (pt_clk),
    .ena     (pt_ena),
    .mode    (mode_w),
    .g_rise  (g_rise_w),
    .t_rise  (t_rise_w),
    .fire    (fire_w)
  );

  rc_state_reg u_st (
    .clk     (sys_clk),
    .rst_n   (rst_n),
    .fire    (fire_w),
    .kind    (kind_w),
    .a       (term_a),
    .b       (term_b),
    .clr_any (clr_any_w),
    .pre_any (pre_any_w),
    .q       (stored_w)
  );

  assign cell_out = (cfg_bypass ? term_a : stored_w) ^ cfg_out_inv;
endmodule

// File: rtl/rc_cell_chk.sv
module rc_cell_chk
  import rcell_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      fire,
  input logic      g_rise,
  input logic      stored,
  input logic      clr_any,
  input logic      pre_any,
  input ff_kind_e  kind,
  input clk_mode_e mode,
  input logic      a,
  input logic      b,
  input logic      ena
);
  // R11: clear dominates
  p_clr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |-> !stored);

  // R11: preset alone holds the bit high
  p_pre_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_any && !clr_any) |-> stored);

  // R7: no event and no async control means the bit keeps its value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr_any && !pre_any) |=> (clr_any || pre_any || stored == $past(stored)));

  // R7: one source edge gives a single event
  p_single_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    g_rise |=> !g_rise);

  // R8: enable low blocks the global event
  p_ena_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CK_GLOBAL_EN && !ena) |-> !fire);

  // R9: mode 3 never fires
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CK_OFF) |-> !fire);

  // R4: J=K=1 toggles
  p_jk_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == FF_JK && a && b && !clr_any && !pre_any)
      |=> (clr_any || pre_any || stored != $past(stored)));

  // R5: S=R=1 holds
  p_sr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == FF_SR && a && b && !clr_any && !pre_any)
      |=> (clr_any || pre_any || stored == $past(stored)));
endmodule

bind prl_reg_cell rc_cell_chk u_chk (
  .clk     (sys_clk),
  .rst_n   (rst_n),
  .fire    (fire_w),
  .g_rise  (g_rise_w),
  .stored  (stored_w),
  .clr_any (clr_any_w),
  .pre_any (pre_any_w),
  .kind    (kind_w),
  .mode    (mode_w),
  .a       (term_a),
  .b       (term_b),
  .ena     (pt_ena)
);

// File: tb/sim_prl_reg_cell.sv
`timescale 1ns/1ps
module sim_prl_reg_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ff_kind = 2'd0, clk_mode = 2'd0;
  logic       bypass = 1'b0, gclr_en = 1'b0, out_inv = 1'b0;
  logic [1:0] gs_pin = 2'b10, gs_inv = 2'b00;
  logic       gs_sel = 1'b0;
  logic       ta = 1'b0, tb = 1'b0;
  logic       ptc = 1'b0, pte = 1'b0, ptp = 1'b0, ptr = 1'b0;
  logic [1:0] gpin = 2'b00;
  logic       gclr = 1'b1;
  logic       q_out;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prl_reg_cell u0 (
    .sys_clk(clk), .rst_n(rst_n), .cfg_ff_kind(ff_kind), .cfg_bypass(bypass),
    .cfg_clk_mode(clk_mode), .cfg_gsrc_pin(gs_pin), .cfg_gsrc_inv(gs_inv),
    .cfg_gsrc_sel(gs_sel), .cfg_gclr_en(gclr_en), .cfg_out_inv(out_inv),
    .term_a(ta), .term_b(tb), .pt_clk(ptc), .pt_ena(pte), .pt_pre(ptp),
    .pt_clr(ptr), .gclk_pin(gpin), .gclr_n(gclr), .cell_out(q_out)
  );

  // {kind[1:0], a, b, expected}; applied in order from stored 0
  localparam logic [4:0] VEC [15] = '{
    5'b00_10_1, 5'b00_00_0,                          // R2 D
    5'b01_10_1, 5'b01_00_1, 5'b01_10_0,              // R3 T
    5'b10_10_1, 5'b10_00_1, 5'b10_11_0, 5'b10_11_1,  // R4 JK
    5'b10_01_0,
    5'b11_10_1, 5'b11_11_1, 5'b11_01_0, 5'b11_11_0,  // R5 SR
    5'b11_00_0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // src 0/1: global pin, 2: product-term clock; high 2 cycles then low 2
  task automatic pulse(input int src);
    @(negedge clk);
    if (src == 2) ptc = 1'b1; else gpin[src] = 1'b1;
    @(negedge clk); @(negedge clk);
    if (src == 2) ptc = 1'b0; else gpin[src] = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #5;
    chk("R1 reset", q_out, 1'b0);
    wait_n(2);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 after release", q_out, 1'b0);

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      ff_kind = VEC[i][4:3]; ta = VEC[i][2]; tb = VEC[i][1];
      pulse(0);
      chk($sformatf("R2-5 vector %0d kind %0d", i, VEC[i][4:3]), q_out, VEC[i][0]);
    end

    // R7 latency and single update per edge
    @(negedge clk); ff_kind = 2'd0; ta = 1'b1; gpin[0] = 1'b1;
    @(negedge clk); chk("R7 not yet", q_out, 1'b0);
    @(negedge clk); chk("R7 second edge", q_out, 1'b1);
    ta = 1'b0;
    wait_n(2); chk("R7 held high no update", q_out, 1'b1);
    gpin[0] = 1'b0;
    wait_n(3); chk("R7 falling no update", q_out, 1'b1);
    pulse(0); chk("R7 next edge", q_out, 1'b0);

    // R10 source 1 = pin0 inverted
    @(negedge clk); gs_pin = 2'b00; gs_inv = 2'b10; gs_sel = 1'b1;
    wait_n(3); ta = 1'b1;
    @(negedge clk); gpin[0] = 1'b1;
    wait_n(3); chk("R10 inverted rise ignored", q_out, 1'b0);
    gpin[0] = 1'b0;
    wait_n(2); chk("R10 inverted event", q_out, 1'b1);
    wait_n(1);
    gs_pin = 2'b10; gs_inv = 2'b00; gs_sel = 1'b0;
    wait_n(3); ta = 1'b0;
    pulse(1); chk("R10 unrouted pin ignored", q_out, 1'b1);

    // R8 enable gating
    @(negedge clk); clk_mode = 2'd1; pte = 1'b0;
    pulse(0); chk("R8 enable low", q_out, 1'b1);
    @(negedge clk); pte = 1'b1;
    pulse(0); chk("R8 enable high", q_out, 1'b0);
    pte = 1'b0;

    // R9 product-term clock and clock off
    @(negedge clk); clk_mode = 2'd2; ta = 1'b1;
    pulse(0); chk("R9 global ignored", q_out, 1'b0);
    pulse(2); chk("R9 term clock", q_out, 1'b1);
    @(negedge clk); clk_mode = 2'd3; ta = 1'b0;
    pulse(2); pulse(0); chk("R9 off holds", q_out, 1'b1);
    @(negedge clk); clk_mode = 2'd0;

    // R11 async controls
    @(negedge clk); ptr = 1'b1; #2; chk("R11 clear async", q_out, 1'b0);
    @(negedge clk); ptr = 1'b0;
    @(negedge clk); ptp = 1'b1; #2; chk("R11 preset async", q_out, 1'b1);
    @(negedge clk); ptr = 1'b1; #2; chk("R11 clear wins", q_out, 1'b0);
    @(negedge clk); chk("R11 clear still wins", q_out, 1'b0);
    ptr = 1'b0; ptp = 1'b0;

    // R12 global clear
    @(negedge clk); ptp = 1'b1;
    @(negedge clk); ptp = 1'b0;
    @(negedge clk); gclr = 1'b0;
    @(negedge clk); chk("R12 disabled", q_out, 1'b1);
    gclr = 1'b1;
    @(negedge clk); gclr_en = 1'b1; gclr = 1'b0; #2;
    chk("R12 enabled clears", q_out, 1'b0);
    @(negedge clk); gclr = 1'b1; gclr_en = 1'b0;

    // R6 bypass
    @(negedge clk); bypass = 1'b1; ta = 1'b1; #2; chk("R6 bypass 1", q_out, 1'b1);
    ta = 1'b0; #2; chk("R6 bypass 0", q_out, 1'b0);
    out_inv = 1'b1; #2; chk("R6 bypass inverted", q_out, 1'b1);
    @(negedge clk); bypass = 1'b0; out_inv = 1'b0;

    // R13 output inversion and power-up high
    @(negedge clk); out_inv = 1'b1; rst_n = 1'b0; #2;
    chk("R13 reset out high", q_out, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    wait_n(2); chk("R13 after release", q_out, 1'b1);
    ptp = 1'b1; #2; chk("R13 stored 1 out 0", q_out, 1'b0);
    @(negedge clk); ptp = 1'b0; out_inv = 1'b0;
    wait_n(1); chk("R13 inversion off", q_out, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule